// File: doc/BRIEF.md
# Spectrum Processor Control Interface

This block links a host processor's byte-wide write bus to the analog front end and to the transform sequencer of a spectrum processor. The host fills staging registers with receiver choices, an attenuation level, a signal-path choice and a bandwidth code. A separate commit write then moves the decoded front-end controls to the outputs, and every one of those outputs changes on the same clock edge. Transform size and sample-rate settings sit in their own register. A start write copies that register onto the sequencer control bus through a small handoff machine. The machine raises a one-cycle valid strobe and holds the bus until the sequencer acknowledges.

The block also checks converter samples in windows of programmable length. A sticky out-of-range flag goes up when a window holds a full-scale code, or when every sample in a window stays under a low threshold. A host read pulse clears the flag. Last, the block takes the delay gate of the committed wideband receiver, passes it through a synchroniser, and turns each rising edge into a pulse of programmable length. Further rising edges that arrive during a pulse are ignored.

Register addresses: 0 path/receiver staging, 1 level staging, 2 commit, 3 transform settings, 4 start, 5 window length, 6 low threshold, 7 stretch length. The handoff machine has the states HO_IDLE, HO_DRIVE, HO_STROBE and HO_HOLD. Its transitions are: IDLE to DRIVE on a start write, DRIVE to STROBE always, STROBE to HOLD always, and HOLD to IDLE on acknowledge. The stretcher has the states GS_WAIT and GS_PULSE. It goes from WAIT to PULSE on a synchronised rising edge, and from PULSE to WAIT when its count reaches zero.

Top module: `spc_ctrl_if`

## Requirements
- R1: Writes to addresses 0 and 1 change no front-end output. A write to address 2 updates all of the front-end outputs together on one clock edge.
- R2: At commit, bits [1:0] of register 0 (value n) give ifsel_o = one-hot bit n, and bits [3:2] (value m) give vidsel_o = one-hot bit m.
- R3: At commit, bits [2:0] of register 1 give an attenuation level L in 10 dB steps, with code 7 treated as 6. att10_o = L[0]. att20_o has its lowest L/2 bits set and the rest clear.
- R4: At commit, bits [5:4] of register 0 choose the source: 00 narrowband (src_nb_n low), 01 wideband (src_wb_n low), 10 or 11 video (src_vid_n low). Exactly one of the three is low.
- R5: At commit, bw_o takes bits [5:3] of register 1.
- R6: In HO_IDLE, a write to address 4 loads seq_data_o with register 3 on that edge. seq_valid_o is then high for exactly one cycle, starting one clock later.
- R7: After the strobe, seq_data_o stays constant until seq_ack_i is seen in HO_HOLD. Start writes and register-3 writes made before the acknowledge do not alter the bus or raise a strobe.
- R8: A window covers (register 5) + 1 valid samples. If any sample in the window is all ones, oor_o goes high on the edge of the window's last sample.
- R9: If every sample in a window has its upper 8 bits below register 6, oor_o goes high on the edge of the window's last sample.
- R10: oor_o stays high until a hst_rd pulse clears it. A new detection in the same cycle as the read wins.
- R11: Only gate_i[n] drives the stretcher, where n is the committed value of register 0 bits [1:0].
- R12: gate_o goes high on the third clock edge after the selected gate rises and stays high for (register 7) + 1 clocks. Rising edges during the pulse are ignored.
- R13: After reset: ifsel_o=0001, vidsel_o=0001, narrowband source selected, no attenuation, bw_o=0, seq_valid_o=0, oor_o=0, gate_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_wr | input | 1 | Host write strobe |
| hst_addr | input | 3 | Host register address |
| hst_wdata | input | 8 | Host write data |
| hst_rd | input | 1 | Host status read pulse, clears oor_o |
| ifsel_o | output | 4 | One-hot wideband IF receiver select |
| vidsel_o | output | 4 | One-hot video receiver select |
| att10_o | output | 1 | 10 dB attenuator step |
| att20_o | output | 3 | 20 dB attenuator steps |
| src_nb_n | output | 1 | Narrowband IF source select, active low |
| src_wb_n | output | 1 | Wideband IF source select, active low |
| src_vid_n | output | 1 | Video source select, active low |
| bw_o | output | 3 | Display bandwidth code |
| seq_data_o | output | 8 | Control data bus to sequencer |
| seq_valid_o | output | 1 | One-cycle valid strobe to sequencer |
| seq_ack_i | input | 1 | Sequencer acknowledge |
| smp_i | input | ADC_W | Converter sample |
| smp_vld_i | input | 1 | Sample valid |
| oor_o | output | 1 | Sticky out-of-range flag |
| gate_i | input | 4 | Receiver delay gates |
| gate_o | output | 1 | Stretched gate pulse |

## Verification
The hardest case to reach is a rising edge on the selected gate that arrives while the stretched pulse is still high. The edge passes through two synchroniser stages, so the input must be dropped early and raised again a few cycles into the pulse. Only then does the synchronised edge land inside GS_PULSE. The bench times that drop and rise against the known three-edge latency, then checks for a single pulse of the programmed width. In the same way, it issues a second start write and a register-3 write during HO_HOLD, before sending the acknowledge, to show that the held bus and the strobe do not react.

// File: rtl/spc_pkg.sv
package spc_pkg;
    localparam int HDW  = 8;
    localparam int HAW  = 3;
    localparam int RX_N = 4;
    localparam int RX_W = $clog2(RX_N);
    localparam int AT20_N = 3;

    localparam logic [HAW-1:0] A_FE_SEL  = 3'd0;
    localparam logic [HAW-1:0] A_FE_LVL  = 3'd1;
    localparam logic [HAW-1:0] A_COMMIT  = 3'd2;
    localparam logic [HAW-1:0] A_XFORM   = 3'd3;
    localparam logic [HAW-1:0] A_START   = 3'd4;
    localparam logic [HAW-1:0] A_WIN     = 3'd5;
    localparam logic [HAW-1:0] A_LOWTHR  = 3'd6;
    localparam logic [HAW-1:0] A_STRETCH = 3'd7;

    typedef enum logic [1:0] {HO_IDLE, HO_DRIVE, HO_STROBE, HO_HOLD} ho_state_t;
    typedef enum logic {GS_WAIT, GS_PULSE} gs_state_t;
endpackage

// File: rtl/spc_fe_regs.sv
module spc_fe_regs
    import spc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic [HAW-1:0]         addr,
    input  logic [HDW-1:0]         wdata,
    output logic [RX_N-1:0]        if_sel,
    output logic [RX_N-1:0]        vid_sel,
    output logic                   att10,
    output logic [AT20_N-1:0]      att20,
    output logic                   nb_n,
    output logic                   wb_n,
    output logic                   vid_n,
    output logic [2:0]             bw,
    output logic [RX_W-1:0]        rx_sel,
    output logic [HDW-1:0]         xform_cfg,
    output logic [HDW-1:0]         win_len,
    output logic [HDW-1:0]         low_thr,
    output logic [HDW-1:0]         str_len
);
    logic [5:0] stg_sel;
    logic [5:0] stg_lvl;
    logic       commit;
    logic [2:0] lvl;
    logic [AT20_N-1:0] att20_nx;

    assign commit = wr && (addr == A_COMMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_sel   <= '0;
            stg_lvl   <= '0;
            xform_cfg <= '0;
            win_len   <= '0;
            low_thr   <= '0;
            str_len   <= '0;
        end else if (wr) begin
            unique case (addr)
                A_FE_SEL:  stg_sel   <= wdata[5:0];
                A_FE_LVL:  stg_lvl   <= wdata[5:0];
                A_XFORM:   xform_cfg <= wdata;
                A_WIN:     win_len   <= wdata;
                A_LOWTHR:  low_thr   <= wdata;
                A_STRETCH: str_len   <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        lvl = (stg_lvl[2:0] == 3'd7) ? 3'd6 : stg_lvl[2:0];
        for (int i = 0; i < AT20_N; i++) att20_nx[i] = (i < int'(lvl[2:1]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            if_sel  <= RX_N'(1);
            vid_sel <= RX_N'(1);
            rx_sel  <= '0;
            att10   <= 1'b0;
            att20   <= '0;
            bw      <= '0;
            nb_n    <= 1'b0;
            wb_n    <= 1'b1;
            vid_n   <= 1'b1;
        end else if (commit) begin
            if_sel  <= RX_N'(1) << stg_sel[1:0];
            vid_sel <= RX_N'(1) << stg_sel[3:2];
            rx_sel  <= stg_sel[1:0];
            att10   <= lvl[0];
            att20   <= att20_nx;
            bw      <= stg_lvl[5:3];
            unique case (stg_sel[5:4])
                2'b00:   {nb_n, wb_n, vid_n} <= 3'b011;
                2'b01:   {nb_n, wb_n, vid_n} <= 3'b101;
                default: {nb_n, wb_n, vid_n} <= 3'b110;
            endcase
        end
    end

    // R1
    fe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable({if_sel, vid_sel, att10, att20, bw, nb_n, wb_n, vid_n}));
    // R4
    src_onecold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({nb_n, wb_n, vid_n}) == 2);
endmodule

// File: rtl/spc_handoff.sv
module spc_handoff
    import spc_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          ack,
    input  logic [CW-1:0] cfg,
    output logic [CW-1:0] seq_data,
    output logic          seq_valid
);
    ho_state_t st, st_nx;

    always_comb begin
        st_nx = st;
        unique case (st)
            HO_IDLE:   if (start) st_nx = HO_DRIVE;
            HO_DRIVE:  st_nx = HO_STROBE;
            HO_STROBE: st_nx = HO_HOLD;
            HO_HOLD:   if (ack) st_nx = HO_IDLE;
            default:   st_nx = HO_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= HO_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      seq_data <= '0;
        else if (st == HO_IDLE && start) seq_data <= cfg;
    end

    assign seq_valid = (st == HO_STROBE);

    // R6
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_valid |=> !seq_valid);
    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == HO_HOLD && !ack) |=> $stable(seq_data));
    // R7
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != HO_IDLE) |=> $stable(seq_data));
endmodule

// File: rtl/spc_range_mon.sv
module spc_range_mon #(
    parameter int ADC_W = 10,
    parameter int WW    = 8,
    parameter int TW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ADC_W-1:0] smp,
    input  logic             vld,
    input  logic [WW-1:0]    win,
    input  logic [TW-1:0]    thr,
    input  logic             clr,
    output logic             oor
);
    logic [WW-1:0] cnt;
    logic any_full, all_low, full_now, low_now, last, hit;

    assign full_now = &smp;
    assign low_now  = smp[ADC_W-1 -: TW] < thr;
    assign last     = cnt >= win;
    assign hit      = vld && last && (any_full || full_now || (all_low && low_now));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            any_full <= 1'b0;
            all_low  <= 1'b1;
        end else if (vld) begin
            if (last) begin
                cnt      <= '0;
                any_full <= 1'b0;
                all_low  <= 1'b1;
            end else begin
                cnt      <= cnt + 1'b1;
                any_full <= any_full | full_now;
                all_low  <= all_low & low_now;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   oor <= 1'b0;
        else if (hit) oor <= 1'b1;
        else if (clr) oor <= 1'b0;
    end

    // R10
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> !oor);
    // R8
    set_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oor) |-> $past(vld));
endmodule

// File: rtl/spc_gate_stretch.sv
module spc_gate_stretch
    import spc_pkg::*;
#(
    parameter int LW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RX_N-1:0] gate_in,
    input  logic [RX_W-1:0] sel,
    input  logic [LW-1:0]   len,
    output logic            gate_o
);
    gs_state_t st, st_nx;
    logic [LW-1:0] cnt;
    logic s1, s2, s3, rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) {s1, s2, s3} <= 3'b000;
        else        {s1, s2, s3} <= {gate_in[sel], s1, s2};
    end

    assign rise = s2 && !s3;

    always_comb begin
        st_nx = st;
        unique case (st)
            GS_WAIT:  if (rise) st_nx = GS_PULSE;
            GS_PULSE: if (cnt == '0) st_nx = GS_WAIT;
            default:  st_nx = GS_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= GS_WAIT;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cnt <= '0;
        else if (st == GS_WAIT && rise)      cnt <= len;
        else if (st == GS_PULSE && cnt != 0) cnt <= cnt - 1'b1;
    end

    assign gate_o = (st == GS_PULSE);

    // R12
    pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == GS_PULSE && cnt != '0) |=> gate_o);
    // R12
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> $past(rise));
endmodule

// File: rtl/spc_ctrl_if.sv
module spc_ctrl_if
    import spc_pkg::*;
#(
    parameter int ADC_W = 10,
    parameter int STR_W = HDW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hst_wr,
    input  logic [HAW-1:0]   hst_addr,
    input  logic [HDW-1:0]   hst_wdata,
    input  logic             hst_rd,
    output logic [RX_N-1:0]  ifsel_o,
    output logic [RX_N-1:0]  vidsel_o,
    output logic             att10_o,
    output logic [AT20_N-1:0] att20_o,
    output logic             src_nb_n,
    output logic             src_wb_n,
    output logic             src_vid_n,
    output logic [2:0]       bw_o,
    output logic [HDW-1:0]   seq_data_o,
    output logic             seq_valid_o,
    input  logic             seq_ack_i,
    input  logic [ADC_W-1:0] smp_i,
    input  logic             smp_vld_i,
    output logic             oor_o,
    input  logic [RX_N-1:0]  gate_i,
    output logic             gate_o
);
    logic [RX_W-1:0] rx_sel;
    logic [HDW-1:0]  xform_cfg, win_len, low_thr, str_len;
    logic            start;

    assign start = hst_wr && (hst_addr == A_START);

    spc_fe_regs u_fe (
        .clk(clk), .rst_n(rst_n), .wr(hst_wr), .addr(hst_addr), .wdata(hst_wdata),
        .if_sel(ifsel_o), .vid_sel(vidsel_o), .att10(att10_o), .att20(att20_o),
        .nb_n(src_nb_n), .wb_n(src_wb_n), .vid_n(src_vid_n), .bw(bw_o),
        .rx_sel(rx_sel), .xform_cfg(xform_cfg), .win_len(win_len),
        .low_thr(low_thr), .str_len(str_len)
    );

    spc_handoff #(.CW(HDW)) u_ho (
        .clk(clk), .rst_n(rst_n), .start(start), .ack(seq_ack_i),
        .cfg(xform_cfg), .seq_data(seq_data_o), .seq_valid(seq_valid_o)
    );

    spc_range_mon #(.ADC_W(ADC_W), .WW(HDW), .TW(HDW)) u_rm (
        .clk(clk), .rst_n(rst_n), .smp(smp_i), .vld(smp_vld_i),
        .win(win_len), .thr(low_thr), .clr(hst_rd), .oor(oor_o)
    );

    spc_gate_stretch #(.LW(STR_W)) u_gs (
        .clk(clk), .rst_n(rst_n), .gate_in(gate_i), .sel(rx_sel),
        .len(str_len[STR_W-1:0]), .gate_o(gate_o)
    );
endmodule

// File: tb/spc_ctrl_if_tb.sv
module spc_ctrl_if_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hst_wr = 1'b0, hst_rd = 1'b0;
    logic [2:0] hst_addr = '0;
    logic [7:0] hst_wdata = '0;
    logic [3:0] ifsel_o, vidsel_o, gate_i = '0;
    logic att10_o, src_nb_n, src_wb_n, src_vid_n, seq_valid_o, oor_o, gate_o;
    logic [2:0] att20_o, bw_o;
    logic [7:0] seq_data_o;
    logic seq_ack_i = 1'b0;
    logic [9:0] smp_i = '0;
    logic smp_vld_i = 1'b0;
    int n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    spc_ctrl_if u_dut (.*);

    task automatic tick(); @(posedge clk); #1; endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
        hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
        tick();
        hst_wr = 1'b0;
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    task automatic t_reset();
        check("R13 ifsel", 32'(ifsel_o), 32'h1);
        check("R13 vidsel", 32'(vidsel_o), 32'h1);
        check("R13 src", 32'({src_nb_n, src_wb_n, src_vid_n}), 32'b011);
        check("R13 att", 32'({att10_o, att20_o}), 0);
        check("R13 bw", 32'(bw_o), 0);
        check("R13 flags", 32'({seq_valid_o, oor_o, gate_o}), 0);
    endtask

    task automatic t_frontend();
        hwrite(3'd0, 8'h1B);
        hwrite(3'd1, 8'h2D);
        check("R1 staged ifsel", 32'(ifsel_o), 32'h1);
        check("R1 staged bw", 32'(bw_o), 0);
        hwrite(3'd2, 8'h00);
        check("R2 ifsel", 32'(ifsel_o), 32'b1000);
        check("R2 vidsel", 32'(vidsel_o), 32'b0100);
        check("R4 wideband", 32'({src_nb_n, src_wb_n, src_vid_n}), 32'b101);
        check("R3 level5", 32'({att10_o, att20_o}), 32'b1_011);
        check("R5 bw", 32'(bw_o), 32'd5);
        hwrite(3'd1, 8'h07);
        hwrite(3'd0, 8'h20);
        hwrite(3'd2, 8'h00);
        check("R3 level7 saturates", 32'({att10_o, att20_o}), 32'b0_111);
        check("R4 video", 32'({src_nb_n, src_wb_n, src_vid_n}), 32'b110);
        check("R2 ifsel0", 32'(ifsel_o), 32'b0001);
        hwrite(3'd1, 8'h01);
        hwrite(3'd0, 8'h31);
        hwrite(3'd2, 8'h00);
        check("R3 level1", 32'({att10_o, att20_o}), 32'b1_000);
        check("R4 code3 video", 32'({src_nb_n, src_wb_n, src_vid_n}), 32'b110);
        hwrite(3'd0, 8'h01);
        hwrite(3'd2, 8'h00);
        check("R4 narrowband", 32'({src_nb_n, src_wb_n, src_vid_n}), 32'b011);
        check("R11 rx1 ifsel", 32'(ifsel_o), 32'b0010);
    endtask

    task automatic t_handoff();
        hwrite(3'd3, 8'hA5);
        hwrite(3'd4, 8'h00);
        check("R6 data", 32'(seq_data_o), 32'hA5);
        check("R6 no early strobe", 32'(seq_valid_o), 0);
        tick();
        check("R6 strobe", 32'(seq_valid_o), 1);
        tick();
        check("R6 strobe ends", 32'(seq_valid_o), 0);
        hwrite(3'd3, 8'h3C);
        hwrite(3'd4, 8'h00);
        tick();
        check("R7 held data", 32'(seq_data_o), 32'hA5);
        check("R7 no restrobe", 32'(seq_valid_o), 0);
        seq_ack_i = 1'b1; tick(); seq_ack_i = 1'b0;
        tick();
        check("R7 no strobe after ack", 32'(seq_valid_o), 0);
        hwrite(3'd4, 8'h00);
        check("R6 new data", 32'(seq_data_o), 32'h3C);
        tick();
        check("R6 new strobe", 32'(seq_valid_o), 1);
        tick();
        seq_ack_i = 1'b1; tick(); seq_ack_i = 1'b0;
    endtask

    task automatic feed(input logic [9:0] v);
        smp_i = v; smp_vld_i = 1'b1; tick(); smp_vld_i = 1'b0;
    endtask

    task automatic hread();
        hst_rd = 1'b1; tick(); hst_rd = 1'b0;
    endtask

    task automatic t_range();
        hwrite(3'd5, 8'd3);
        hwrite(3'd6, 8'h10);
        for (int i = 0; i < 4; i++) feed(10'h200);
        check("R8 mid no flag", 32'(oor_o), 0);
        feed(10'h200); feed(10'h3FF); feed(10'h200);
        check("R8 before window end", 32'(oor_o), 0);
        feed(10'h200);
        check("R8 full scale", 32'(oor_o), 1);
        tick(); tick();
        check("R10 sticky", 32'(oor_o), 1);
        hread();
        check("R10 cleared", 32'(oor_o), 0);
        for (int i = 0; i < 3; i++) feed(10'h010);
        feed(10'h200);
        check("R9 not all low", 32'(oor_o), 0);
        for (int i = 0; i < 4; i++) feed(10'h010);
        check("R9 all low", 32'(oor_o), 1);
        hread();
    endtask

    task automatic t_gate(input string req, input int line, input bit retrig,
                          input int exp_first, input int exp_width);
        int first = -1;
        int highs = 0;
        gate_i[line] = 1'b1;
        for (int t = 1; t <= 20; t++) begin
            tick();
            if (retrig && t == 1) gate_i[line] = 1'b0;
            if (retrig && t == 4) gate_i[line] = 1'b1;
            if (gate_o && first < 0) first = t;
            if (gate_o) highs++;
        end
        check({req, " start"}, 32'(first), 32'(exp_first));
        check({req, " width"}, 32'(highs), 32'(exp_width));
        gate_i = '0;
        repeat (4) tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        report();
    end

    initial begin
        #12 rst_n = 1'b1;
        tick();
        t_reset();
        t_frontend();
        t_handoff();
        t_range();
        hwrite(3'd7, 8'd4);
        t_gate("R12 stretch", 1, 1'b0, 3, 5);
        t_gate("R12 retrigger", 1, 1'b1, 3, 5);
        t_gate("R11 unselected", 2, 1'b0, -1, 0);
        hwrite(3'd0, 8'h02);
        hwrite(3'd2, 8'h00);
        t_gate("R11 reselected", 2, 1'b0, 3, 5);
        report();
    end
endmodule